// File: doc/BRIEF.md
# Rotating Bus Arbiter with Host Hold Handshake

This block decides which agent may drive a shared PCI bus. Five agents compete: four external bus masters, each with an active-low request and grant pin, and one on-chip system I/O agent. The on-chip agent always comes first. The four masters share the rest of the bus time through a binary tree of toggle switches. A root switch picks between the pair {0,1} and the pair {2,3}. One leaf switch per pair picks a member of that pair. Every switch on the path to a granted master flips to point away from the branch that was just served. The on-chip agent's grants leave the tree alone.

The host CPU owns the bus by default. Before any grant is issued, the arbiter raises `cpu_hold` and waits for `cpu_hlda`. A grant is given or taken away only while the bus is idle, which means FRAME# and IRDY# are both high. Once the owner withdraws its request and nobody else is waiting, the hold is released so the CPU gets the bus back.

The control is a three-state machine:
- **IDLE**: no hold, no grant.
- **HOLD**: hold raised, no grant.
- **OWN**: one grant is driven.

The transitions are:
- *request seen*: IDLE to HOLD, on any request.
- *all withdrawn*: HOLD to IDLE, when no request remains.
- *granted*: HOLD to OWN, when `cpu_hlda` is high, the bus is idle and at least one request is present.
- *handoff*: OWN to HOLD, at bus idle, when the owner has dropped its request or the on-chip agent preempts a master, and some request is still present.
- *released*: OWN to IDLE, at bus idle, when the owner has dropped its request and no request remains.

Top module: `pci_bus_arbiter`

## Requirements
- R1: After reset, `cpu_hold` is low and all grant pins are high. The first master arbitration prefers masters in the order 0, 1, 2, 3.
- R2: A request raises `cpu_hold` one clock later. No grant is driven until `cpu_hlda` has been sampled high. Once it is seen high with the bus idle, the grant appears one clock later.
- R3: When the on-chip agent requests, it receives the next grant regardless of which masters are also requesting.
- R4: With all four masters requesting and each owner leaving in turn, the grants from reset follow the sequence 0, 2, 1, 3, 0.
- R5: The preferred master is the one the switch tree selects. The root switch picks a pair, falling back to the other pair if the preferred pair has no request. The leaf switch then picks a member, falling back likewise. After a master grant, the root points to the other pair and the granted pair's leaf points to the other member. The opposite pair's leaf keeps its setting.
- R6: A grant is never given or removed while FRAME# or IRDY# is low. The owner keeps its grant for as long as it requests.
- R7: If a master owns the bus and the on-chip agent requests, that master's grant is removed at the next idle clock. The on-chip agent is granted one clock later.
- R8: At most one of the five grant pins is low at any time.
- R9: When the owner drops its request with the bus idle and nothing else is pending, `cpu_hold` falls within two clocks and no grant remains.
- R10: A grant to the on-chip agent leaves the master rotation unchanged.
- R11: When the owner drops its request while others are pending, `cpu_hold` stays high. There is one clock without a grant, then the next winner is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 4 | Master requests, active low, bit i is master i |
| io_req_n | input | 1 | On-chip agent request, active low |
| gnt_n | output | 4 | Master grants, active low, bit i is master i |
| io_gnt_n | output | 1 | On-chip agent grant, active low |
| cpu_hold | output | 1 | Asks the host CPU to give up the bus |
| cpu_hlda | input | 1 | Host CPU acknowledges the hold |
| frame_n | input | 1 | Bus FRAME#, low while a transaction is in progress |
| irdy_n | input | 1 | Bus IRDY#, low while the initiator is ready |

## Verification
The bench sweeps every nonzero mix of master requests across many tree states, with the on-chip agent mixed in at intervals. A tree that toggles the wrong leaf or skips the fallback to the other pair then grants a master out of turn. A design that lets on-chip grants touch the switches would drift from the expected order after such rounds. Directed cases hold FRAME# or IRDY# low during a handoff, so a design that re-arbitrates during a busy bus changes grant early. Further cases hold off `cpu_hlda`, so an arbiter that skips the handshake grants too soon. The remaining cases check preemption by the on-chip agent and the handoff gap between owners. A late hold release or a missing idle clock would show up there.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_OWN  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/pci_arb_switch_tree.sv
module pci_arb_switch_tree #(
    parameter int LEVELS = 2,
    localparam int NUM_MST = 1 << LEVELS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] req,
    input  logic               upd,
    input  logic [LEVELS-1:0]  upd_idx,
    output logic [LEVELS-1:0]  win_idx,
    output logic               any_req
);

    localparam int NODES = 2 * NUM_MST;
    localparam logic [LEVELS:0] ONE = {{LEVELS{1'b0}}, 1'b1};

    // Heap-numbered nodes: node n has children 2n and 2n+1, leaves are masters.
    logic [NODES-1:1]   any_n;
    logic [NUM_MST-1:1] sw;
    logic [NUM_MST-1:1] sw_nxt;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MST; gi++) begin : g_leaf
            assign any_n[NUM_MST + gi] = req[gi];
        end
        for (gi = 1; gi < NUM_MST; gi++) begin : g_node
            assign any_n[gi] = any_n[2*gi] | any_n[2*gi + 1];
        end
    endgenerate

    assign any_req = any_n[1];

    // Walk from the root toward the preferred branch, falling back when empty.
    logic [LEVELS:0] walk;
    logic [LEVELS:0] lft;
    logic [LEVELS:0] pref;
    always_comb begin
        walk = ONE;
        lft  = '0;
        pref = '0;
        for (int k = 0; k < LEVELS; k++) begin
            lft  = {walk[LEVELS-1:0], 1'b0};
            pref = sw[walk[LEVELS-1:0]] ? (lft | ONE) : lft;
            walk = any_n[pref] ? pref : (pref ^ ONE);
        end
        win_idx = walk[LEVELS-1:0];
    end

    // Every switch on the path to the granted leaf points away from it.
    logic [LEVELS:0] leaf;
    logic [LEVELS:0] anc;
    logic [LEVELS:0] chld;
    always_comb begin
        sw_nxt = sw;
        leaf   = {1'b1, upd_idx};
        anc    = '0;
        chld   = '0;
        if (upd) begin
            for (int k = 1; k <= LEVELS; k++) begin
                anc  = leaf >> k;
                chld = leaf >> (k - 1);
                sw_nxt[anc[LEVELS-1:0]] = ~chld[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw <= '0;
        else        sw <= sw_nxt;
    end

    // R5: root turns to the pair that was not just served
    p_root_away_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (sw[1] == ~$past(upd_idx[LEVELS-1])));

    // R10: switches move only on a master grant
    p_sw_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(sw));

endmodule

// File: rtl/pci_arb_grant_fsm.sv
module pci_arb_grant_fsm
    import pci_arb_pkg::*;
#(
    parameter int LEVELS = 2,
    localparam int NUM_MST = 1 << LEVELS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_req,
    input  logic [NUM_MST-1:0] mst_req,
    input  logic               any_mst,
    input  logic [LEVELS-1:0]  win_idx,
    input  logic               hlda,
    input  logic               bus_idle,
    output logic               hold_o,
    output logic [NUM_MST-1:0] mst_gnt,
    output logic               io_gnt,
    output logic               upd,
    output logic [LEVELS-1:0]  upd_idx
);

    arb_state_e        state;
    arb_state_e        state_nxt;
    logic              owner_io;
    logic [LEVELS-1:0] owner_idx;
    logic              any_req;
    logic              owner_req;
    logic              take_bus;
    logic              give_up;

    assign any_req   = io_req | any_mst;
    assign owner_req = owner_io ? io_req : mst_req[owner_idx];
    assign take_bus  = (state == ST_HOLD) && hlda && bus_idle && any_req;
    assign give_up   = (state == ST_OWN) && bus_idle &&
                       (!owner_req || (!owner_io && io_req));

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (any_req) state_nxt = ST_HOLD;
            ST_HOLD: begin
                if (!any_req)      state_nxt = ST_IDLE;
                else if (take_bus) state_nxt = ST_OWN;
            end
            ST_OWN:  if (give_up) state_nxt = any_req ? ST_HOLD : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Owner register, loaded on the granted transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_io  <= 1'b0;
            owner_idx <= '0;
        end else if (take_bus) begin
            owner_io  <= io_req;
            owner_idx <= win_idx;
        end
    end

    assign upd     = take_bus && !io_req;
    assign upd_idx = win_idx;

    // Outputs decoded from registered state only
    always_comb begin
        hold_o  = 1'b0;
        mst_gnt = '0;
        io_gnt  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_HOLD: hold_o = 1'b1;
            ST_OWN: begin
                hold_o = 1'b1;
                if (owner_io) io_gnt = 1'b1;
                else          mst_gnt[owner_idx] = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: a grant starts only after the hold was acknowledged
    p_hlda_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OWN && $past(state) == ST_HOLD) |-> $past(hlda));

    // R3: the on-chip agent wins any arbitration it joins
    p_io_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && hlda && bus_idle && io_req) |=> io_gnt);

    // R6: grants appear or vanish only on an idle bus
    p_idle_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != $past(state)) && (state == ST_OWN || $past(state) == ST_OWN))
        |-> $past(bus_idle));

    // R9: nothing pending after the owner leaves releases the hold
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OWN && bus_idle && !any_req) |=> !hold_o);

endmodule

// File: rtl/pci_bus_arbiter.sv
module pci_bus_arbiter #(
    parameter int LEVELS = 2,
    localparam int NUM_MST = 1 << LEVELS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] req_n,
    input  logic               io_req_n,
    output logic [NUM_MST-1:0] gnt_n,
    output logic               io_gnt_n,
    output logic               cpu_hold,
    input  logic               cpu_hlda,
    input  logic               frame_n,
    input  logic               irdy_n
);

    logic [NUM_MST-1:0] mst_req;
    logic [NUM_MST-1:0] mst_gnt;
    logic               io_req;
    logic               io_gnt;
    logic               bus_idle;
    logic               any_mst;
    logic               upd;
    logic [LEVELS-1:0]  upd_idx;
    logic [LEVELS-1:0]  win_idx;

    assign mst_req  = ~req_n;
    assign io_req   = ~io_req_n;
    assign bus_idle = frame_n & irdy_n;

    pci_arb_switch_tree #(.LEVELS(LEVELS)) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (mst_req),
        .upd     (upd),
        .upd_idx (upd_idx),
        .win_idx (win_idx),
        .any_req (any_mst)
    );

    pci_arb_grant_fsm #(.LEVELS(LEVELS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_req  (io_req),
        .mst_req (mst_req),
        .any_mst (any_mst),
        .win_idx (win_idx),
        .hlda    (cpu_hlda),
        .bus_idle(bus_idle),
        .hold_o  (cpu_hold),
        .mst_gnt (mst_gnt),
        .io_gnt  (io_gnt),
        .upd     (upd),
        .upd_idx (upd_idx)
    );

    assign gnt_n    = ~mst_gnt;
    assign io_gnt_n = ~io_gnt;

    // R8: never two owners
    p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_gnt, mst_gnt}));

endmodule

// File: tb/pci_bus_arbiter_test.sv
module pci_bus_arbiter_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_n = 4'hF;
    logic       io_req_n = 1'b1;
    logic [3:0] gnt_n;
    logic       io_gnt_n;
    logic       cpu_hold;
    logic       cpu_hlda = 1'b1;
    logic       frame_n = 1'b1;
    logic       irdy_n = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Switch model: root 1 = prefer pair {2,3}; la 1 = prefer 1; lb 1 = prefer 3
    bit m_root = 1'b0;
    bit m_la = 1'b0;
    bit m_lb = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_bus_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .io_req_n(io_req_n),
        .gnt_n(gnt_n), .io_gnt_n(io_gnt_n), .cpu_hold(cpu_hold),
        .cpu_hlda(cpu_hlda), .frame_n(frame_n), .irdy_n(irdy_n)
    );

    function automatic int mwin(input logic [3:0] m);
        int g;
        if (!m_root) g = (m[1:0] != 0) ? 0 : 1;
        else         g = (m[3:2] != 0) ? 1 : 0;
        if (g == 0) return (!m_la) ? (m[0] ? 0 : 1) : (m[1] ? 1 : 0);
        else        return (!m_lb) ? (m[2] ? 2 : 3) : (m[3] ? 3 : 2);
    endfunction

    task automatic mupd(input int w);
        m_root = (w < 2);
        if (w < 2) m_la = (w == 0);
        else       m_lb = (w == 2);
    endtask

    function automatic logic [4:0] vec(input bit io, input int w);
        if (io) return 5'b10000;
        return 5'(1 << w);
    endfunction

    function automatic logic [4:0] obs();
        return {~io_gnt_n, ~gnt_n};
    endfunction

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One arbitration from IDLE: request, grant, full release
    task automatic round(input logic [3:0] mask, input bit io, input string tag);
        int w;
        w = mwin(mask);
        req_n = ~mask;
        io_req_n = ~io;
        step(1);
        chk({tag, " R2 hold raised"}, {4'b0, cpu_hold}, 5'd1);
        chk({tag, " R2 no grant yet"}, obs(), 5'd0);
        step(1);
        chk({tag, " R3/R5 winner"}, obs(), vec(io, w));
        chk({tag, " R8 single"}, 5'($countones(obs()) <= 1), 5'd1);
        if (!io) mupd(w);
        req_n = 4'hF;
        io_req_n = 1'b1;
        step(1);
        chk({tag, " R9 hold off"}, {4'b0, cpu_hold}, 5'd0);
        chk({tag, " R9 no grant"}, obs(), 5'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int w;
        step(2);
        chk("R1 reset grants", obs(), 5'd0);
        chk("R1 reset hold", {4'b0, cpu_hold}, 5'd0);
        rst_n = 1'b1;
        step(1);

        // R1/R4: all masters requesting from reset: 0,2,1,3,0
        begin
            int seq[5] = '{0, 2, 1, 3, 0};
            for (int i = 0; i < 5; i++) begin
                req_n = 4'h0;
                step(2);
                chk($sformatf("R4 step %0d", i), obs(), vec(0, seq[i]));
                mupd(seq[i]);
                req_n = 4'hF;
                step(1);
            end
        end

        // Sweep of request mixes with occasional on-chip requests (R3, R5, R10)
        for (int k = 0; k < 90; k++) begin
            round(4'(((k * 7) % 15) + 1), (k % 6) == 5, $sformatf("sweep%0d", k));
        end

        // R2: no grant while hlda is held low
        cpu_hlda = 1'b0;
        req_n = 4'b1011;
        step(4);
        chk("R2 hold waiting", {4'b0, cpu_hold}, 5'd1);
        chk("R2 blocked", obs(), 5'd0);
        cpu_hlda = 1'b1;
        step(1);
        chk("R2 granted after hlda", obs(), vec(0, 2));
        mupd(2);
        req_n = 4'hF;
        step(1);

        // R6: busy bus delays both grant and release
        frame_n = 1'b0;
        req_n = 4'b1110;
        step(3);
        chk("R6 no grant while busy", obs(), 5'd0);
        frame_n = 1'b1;
        step(1);
        chk("R6 grant at idle", obs(), vec(0, 0));
        mupd(0);
        frame_n = 1'b0;
        req_n = 4'hF;
        step(2);
        chk("R6 kept while frame low", obs(), vec(0, 0));
        frame_n = 1'b1;
        irdy_n = 1'b0;
        step(1);
        chk("R6 kept while irdy low", obs(), vec(0, 0));
        irdy_n = 1'b1;
        step(1);
        chk("R6 released at idle", obs(), 5'd0);
        chk("R9 hold dropped", {4'b0, cpu_hold}, 5'd0);

        // R7: on-chip agent preempts an owning master
        req_n = 4'b0111;
        step(2);
        chk("R7 master owns", obs(), vec(0, 3));
        mupd(3);
        io_req_n = 1'b0;
        step(1);
        chk("R7 master removed", obs(), 5'd0);
        chk("R7 hold kept", {4'b0, cpu_hold}, 5'd1);
        step(1);
        chk("R7 io granted", obs(), vec(1, 0));
        io_req_n = 1'b1;
        step(2);
        chk("R10 master back", obs(), vec(0, 3));
        mupd(3);
        req_n = 4'hF;
        step(1);

        // R11: handoff between two masters
        req_n = 4'b1100;
        step(2);
        w = mwin(4'b0011);
        chk("R11 first owner", obs(), vec(0, w));
        mupd(w);
        req_n = (w == 0) ? 4'b1101 : 4'b1110;
        step(1);
        chk("R11 gap clock", obs(), 5'd0);
        chk("R11 hold kept", {4'b0, cpu_hold}, 5'd1);
        step(1);
        chk("R11 next owner", obs(), vec(0, 1 - w));
        mupd(1 - w);
        req_n = 4'hF;
        step(1);
        chk("R9 final release", {4'b0, cpu_hold}, 5'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule